// File: doc/BRIEF.md
# Device-to-Memory DMA Engine

This block copies a run of words arriving from a device stream into physical memory with no per-word help from the processor. Software writes a physical start address and a byte count into memory-mapped registers. It then writes a command word that, in a single write, selects the input stream, sets the interrupt enable and sets the transfer enable. The engine then takes words from the selected ready/valid stream and issues one memory write request per word, at ascending word addresses.

A programmed transfer is cut into segments that never run past a page boundary, so that each segment is one physically contiguous piece. The request that closes a segment carries a marker. The engine keeps one write in flight and waits for each response before it issues the next request. A completed transfer sets a done flag. A misaligned setup or an error response sets an error flag instead. Either flag raises the interrupt when interrupts are enabled, and software clears each flag by writing 1 to it.

Top module: `dev2mem_dma`

## Requirements
- R1: After reset all four registers (start address at word offset 0, count at offset 1, command at offset 2, status at offset 3) read 0, `irq` is 0 and no memory request is valid.
- R2: Command bit 0 enables the transfer, bit 1 enables the interrupt, and bits starting at 2 select the input stream. Writing the command with bit 0 set while idle, with an aligned non-zero count, starts a transfer, and status bit 2 (busy) reads 1 until the transfer ends.
- R3: The word at index k of the transfer goes to start address + 4k, and its data is the k-th word accepted from the selected stream. Only the selected stream sees `srcReady`.
- R4: `memReqLast` is 1 on a request whose address is the last word of a page (address mod PAGE_BYTES = PAGE_BYTES-4) or that carries the final word of the transfer, and 0 on all other requests.
- R5: After a request is accepted, no new request is valid until the memory response for it has arrived.
- R6: When the last response returns without error, status bit 0 (done) sets, busy clears and command bit 0 reads 0.
- R7: `irq` is 1 exactly when command bit 1 is set and either status bit 0 or status bit 1 is set.
- R8: A start with a start address or count whose low two bits are not zero sets status bit 1 (error), issues no request and leaves command bit 0 at 0.
- R9: An error response ends the transfer at once: status bit 1 sets, no further request is issued and command bit 0 reads 0.
- R10: Writing status with 1 in bit 0 or bit 1 clears that bit only, and `irq` falls with it.
- R11: While busy, writes to the start address, count and command registers are ignored, and the transfer keeps its programmed address sequence.
- R12: A start with count 0 sets done at once and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word offset |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for `regAddr` (combinational) |
| srcValid | input | NUM_SRC | Per-stream word valid |
| srcData | input | NUM_SRC*DATA_W | Per-stream word data, stream i at bits i*DATA_W |
| srcReady | output | NUM_SRC | Per-stream word accept |
| memReqValid | output | 1 | Memory write request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Physical byte address of the write |
| memReqData | output | DATA_W | Write data |
| memReqLast | output | 1 | Request closes a page-bounded segment |
| memRspValid | input | 1 | Write response valid |
| memRspErr | input | 1 | Write response reports an error |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with PAGE_BYTES set to 64, so a page holds 16 words. With that size, transfers of a few dozen words cross two or three page boundaries, and both a segment split just after the start and a transfer of exactly one full page can be reached within a short run. NUM_SRC is 2, which lets the bench watch the unselected stream for a stray ready. CNT_W stays at 16, and ADDR_W and DATA_W stay at 32.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] REG_BASE   = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_CMD    = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;

  typedef struct packed {
    logic launch;
    logic step;
    logic endOk;
    logic endErr;
    logic issue;
    logic active;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_WAIT = 2'd2
  } dmaState_t;
endpackage

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        goReq,
  input  logic        cfgBad,
  input  logic        cfgZero,
  input  logic        remZero,
  input  logic        selValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspErr,
  output ctlStrobes_t strb
);
  dmaState_t state, nxtState;

  always_comb begin
    strb = '0;
    nxtState = state;
    strb.active = (state != ST_IDLE);
    strb.issue = (state == ST_MOVE);
    unique case (state)
      ST_IDLE: begin
        if (goReq) begin
          if (cfgBad) begin
            strb.endErr = 1'b1;
          end else if (cfgZero) begin
            strb.endOk = 1'b1;
          end else begin
            strb.launch = 1'b1;
            nxtState = ST_MOVE;
          end
        end
      end
      ST_MOVE: begin
        if (selValid && memReqReady) begin
          strb.step = 1'b1;
          nxtState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strb.endErr = 1'b1;
            nxtState = ST_IDLE;
          end else if (remZero) begin
            strb.endOk = 1'b1;
            nxtState = ST_IDLE;
          end else begin
            nxtState = ST_MOVE;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && memRspValid && memRspErr) |=> !strb.active); // R9
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int NUM_SRC    = 2,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [1:0]                regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [NUM_SRC-1:0]        srcValid,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  output logic [NUM_SRC-1:0]        srcReady,
  input  logic                      memReqReady,
  output logic                      memReqValid,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [DATA_W-1:0]         memReqData,
  output logic                      memReqLast,
  output logic                      irq,
  input  ctlStrobes_t               strb,
  output logic                      goReq,
  output logic                      cfgBad,
  output logic                      cfgZero,
  output logic                      remZero,
  output logic                      selValid
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_LSB   = $clog2(WORD_BYTES);
  localparam int PAGE_LSB   = $clog2(PAGE_BYTES);
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [ADDR_W-1:0] baseReg, curAddr;
  logic [CNT_W-1:0]  countReg, remBytes;
  logic              cmdEn, cmdIrq, doneBit, errBit;
  logic [SEL_W-1:0]  cmdSel;
  logic [NUM_SRC-1:0] hit;
  logic [DATA_W-1:0] selData;
  logic              pageEnd;

  wire wrIdle = regWrEn && !strb.active;

  // source selection
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = (cmdSel == SEL_W'(g));
    assign srcReady[g] = strb.issue && hit[g] && memReqReady;
  end

  always_comb begin
    selData = '0;
    for (int i = 0; i < NUM_SRC; i++)
      selData = selData | (srcData[i*DATA_W +: DATA_W] & {DATA_W{hit[i]}});
  end

  assign selValid    = |(srcValid & hit);
  assign goReq       = wrIdle && (regAddr == REG_CMD) && regWrData[0];
  assign cfgBad      = (baseReg[WORD_LSB-1:0] != '0) || (countReg[WORD_LSB-1:0] != '0);
  assign cfgZero     = (countReg == '0);
  assign remZero     = (remBytes == '0);
  assign pageEnd     = &curAddr[PAGE_LSB-1:WORD_LSB];
  assign memReqValid = strb.issue && selValid;
  assign memReqAddr  = curAddr;
  assign memReqData  = selData;
  assign memReqLast  = pageEnd || (remBytes == CNT_W'(WORD_BYTES));
  assign irq         = cmdIrq && (doneBit || errBit);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      countReg <= '0;
      cmdEn    <= 1'b0;
      cmdIrq   <= 1'b0;
      cmdSel   <= '0;
    end else begin
      if (wrIdle && regAddr == REG_BASE)  baseReg  <= regWrData[ADDR_W-1:0];
      if (wrIdle && regAddr == REG_COUNT) countReg <= regWrData[CNT_W-1:0];
      if (wrIdle && regAddr == REG_CMD) begin
        cmdEn  <= regWrData[0];
        cmdIrq <= regWrData[1];
        cmdSel <= regWrData[2 +: SEL_W];
      end
      if (strb.endOk || strb.endErr) cmdEn <= 1'b0;
    end
  end

  // status flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneBit <= 1'b0;
      errBit  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == REG_STATUS && regWrData[0]) doneBit <= 1'b0;
      if (regWrEn && regAddr == REG_STATUS && regWrData[1]) errBit  <= 1'b0;
      if (strb.endOk)  doneBit <= 1'b1;
      if (strb.endErr) errBit  <= 1'b1;
    end
  end

  // working address and remaining byte count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
    end else if (strb.launch) begin
      curAddr  <= baseReg;
      remBytes <= countReg;
    end else if (strb.step) begin
      curAddr  <= curAddr + ADDR_W'(WORD_BYTES);
      remBytes <= remBytes - CNT_W'(WORD_BYTES);
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_BASE:  regRdData = DATA_W'(baseReg);
      REG_COUNT: regRdData = DATA_W'(countReg);
      REG_CMD:   regRdData = DATA_W'({cmdSel, cmdIrq, cmdEn});
      default:   regRdData = DATA_W'({strb.active, errBit, doneBit});
    endcase
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && $past(strb.active)) |-> ($stable(baseReg) && $stable(countReg))); // R11
  AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !memReqLast) |=> (curAddr[PAGE_LSB-1:0] != '0)); // R4
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.active) |-> !cmdEn); // R6
  AST_BAD_NOSTART: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && cfgBad) |=> (!strb.active && errBit && !cmdEn)); // R8
endmodule

// File: rtl/dev2mem_dma.sv
module dev2mem_dma
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int NUM_SRC    = 2,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [1:0]                regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [NUM_SRC-1:0]        srcValid,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  output logic [NUM_SRC-1:0]        srcReady,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [DATA_W-1:0]         memReqData,
  output logic                      memReqLast,
  input  logic                      memRspValid,
  input  logic                      memRspErr,
  output logic                      irq
);
  ctlStrobes_t strb;
  logic goReq, cfgBad, cfgZero, remZero, selValid;

  dma_control u_control (
    .clk(clk), .rstN(rstN), .goReq(goReq), .cfgBad(cfgBad), .cfgZero(cfgZero),
    .remZero(remZero), .selValid(selValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .strb(strb)
  );

  dma_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .NUM_SRC(NUM_SRC), .PAGE_BYTES(PAGE_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .memReqReady(memReqReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memReqLast(memReqLast), .irq(irq), .strb(strb), .goReq(goReq),
    .cfgBad(cfgBad), .cfgZero(cfgZero), .remZero(remZero), .selValid(selValid)
  );
endmodule

// File: tb/dev2mem_dma_bench.sv
module dev2mem_dma_bench;
  localparam int ADDR_W = 32, DATA_W = 32, CNT_W = 16, NUM_SRC = 2, PAGE_BYTES = 64;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] count;
    logic        sel;
    logic        irqEn;
    logic [7:0]  errWord;
    logic        stall;
    logic [7:0]  expWords;
    logic [3:0]  expLasts;
    logic        expDone;
    logic        expErr;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{32'h100, 16'd16,  1'b0, 1'b1, 8'hFF, 1'b0, 8'd4,  4'd1, 1'b1, 1'b0},
    '{32'h138, 16'd32,  1'b1, 1'b0, 8'hFF, 1'b1, 8'd8,  4'd2, 1'b1, 1'b0},
    '{32'h200, 16'd160, 1'b0, 1'b1, 8'hFF, 1'b0, 8'd40, 4'd3, 1'b1, 1'b0},
    '{32'h3F8, 16'd24,  1'b1, 1'b1, 8'd2,  1'b0, 8'd3,  4'd1, 1'b0, 1'b1},
    '{32'h102, 16'd8,   1'b0, 1'b1, 8'hFF, 1'b0, 8'd0,  4'd0, 1'b0, 1'b1},
    '{32'h100, 16'd6,   1'b0, 1'b0, 8'hFF, 1'b0, 8'd0,  4'd0, 1'b0, 1'b1},
    '{32'h140, 16'd0,   1'b1, 1'b1, 8'hFF, 1'b0, 8'd0,  4'd0, 1'b1, 1'b0},
    '{32'h7C0, 16'd64,  1'b1, 1'b1, 8'hFF, 1'b1, 8'd16, 4'd1, 1'b1, 1'b0},
    '{32'h600, 16'd8,   1'b0, 1'b0, 8'd0,  1'b0, 8'd1,  4'd0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [DATA_W-1:0] regWrData = '0, regRdData;
  logic [NUM_SRC-1:0] srcValid = '0, srcReady;
  logic [NUM_SRC*DATA_W-1:0] srcData = '0;
  logic memReqValid, memReqReady = 1'b1, memReqLast;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqData;
  logic memRspValid = 1'b0, memRspErr = 1'b0, irq;

  int checks = 0, errors = 0;
  int seq [NUM_SRC];
  bit accPrev [NUM_SRC];
  bit pending = 0, pendErr = 0, rspNow, stallOn = 0, curSel = 0;
  int wordIdx = 0, lastCnt = 0, errAt = -1, cyc = 0;
  logic [31:0] expAddr = '0, endAddr = '0;

  always #5 clk = ~clk;

  dev2mem_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                .NUM_SRC(NUM_SRC), .PAGE_BYTES(PAGE_BYTES)) u_dev2mem_dma (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memReqLast(memReqLast), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // device streams, memory responder and request monitor
  initial begin
    for (int i = 0; i < NUM_SRC; i++) begin seq[i] = 0; accPrev[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NUM_SRC; i++) begin
        if (accPrev[i]) seq[i]++;
        srcData[i*DATA_W +: DATA_W] = {8'(i + 1), 24'(seq[i])};
        srcValid[i] = stallOn ? (((cyc + i) % 4) != 1) : 1'b1;
      end
      rspNow = pending;
      memRspValid = pending;
      memRspErr = pendErr;
      pending = 0;
      pendErr = 0;
      cyc++;
      memReqReady = stallOn ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (rspNow) check(!memReqValid, "R5", "request while response due", 32'(memReqValid), 32'd0);
      for (int i = 0; i < NUM_SRC; i++) accPrev[i] = srcValid[i] && srcReady[i];
      if (memReqValid && memReqReady) begin
        automatic bit expLast = ((expAddr % PAGE_BYTES) == PAGE_BYTES - 4) || (expAddr + 4 == endAddr);
        automatic logic [31:0] expData = {8'(curSel + 1), 24'(seq[curSel])};
        check(memReqAddr == expAddr, "R3", "write address", memReqAddr, expAddr);
        check(memReqData == expData, "R3", "write data", memReqData, expData);
        check(memReqLast == expLast, "R4", "segment last flag", 32'(memReqLast), 32'(expLast));
        check(srcReady[!curSel] == 1'b0, "R3", "unselected stream ready", 32'(srcReady[!curSel]), 32'd0);
        if (wordIdx == errAt) pendErr = 1;
        pending = 1;
        wordIdx++;
        if (memReqLast) lastCnt++;
        expAddr = expAddr + 4;
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #2;
    v = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    int n = 0;
    do begin
      regRead(2'd3, st);
      n++;
    end while (st[2] && n < 3000);
    check(n < 3000, "R6", "transfer did not end", st, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic prepare(input logic [31:0] base, input logic [15:0] count,
                         input bit sel, input bit stall, input int errIdx);
    stallOn = stall; curSel = sel; errAt = errIdx;
    wordIdx = 0; lastCnt = 0; expAddr = base; endAddr = base + 32'(count);
  endtask

  task automatic runRow(input row_t r);
    logic [31:0] v;
    string tag;
    prepare(r.base, r.count, r.sel, r.stall, (r.errWord == 8'hFF) ? -1 : int'(r.errWord));
    regWrite(2'd0, r.base);
    regWrite(2'd1, 32'(r.count));
    regWrite(2'd2, {29'd0, r.sel, r.irqEn, 1'b1});
    if (r.expWords != 0) begin
      regRead(2'd3, v);
      check(v[2] == 1'b1, "R2", "busy after start", v, 32'h4);
    end
    waitIdle();
    tag = r.expErr ? ((r.expWords == 0) ? "R8" : "R9") : ((r.count == 0) ? "R12" : "R6");
    regRead(2'd3, v);
    check(v[2:0] == {1'b0, r.expErr, r.expDone}, tag, "status", v, {29'd0, 1'b0, r.expErr, r.expDone});
    check(wordIdx == int'(r.expWords), tag, "words written", wordIdx, 32'(r.expWords));
    check(lastCnt == int'(r.expLasts), "R4", "segment count", lastCnt, 32'(r.expLasts));
    regRead(2'd2, v);
    check(v[0] == 1'b0, "R6", "enable self-clear", v, 32'd0);
    check(irq == (r.irqEn && (r.expDone || r.expErr)), "R7", "irq level", 32'(irq),
          32'(r.irqEn && (r.expDone || r.expErr)));
    regWrite(2'd3, 32'h3);
    regRead(2'd3, v);
    check(v[1:0] == 2'b00, "R10", "status after clear", v, 32'd0);
    check(irq == 1'b0, "R10", "irq after clear", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      check(v == 32'd0, "R1", "register after reset", v, 32'd0);
    end
    check(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);
    check(memReqValid == 1'b0, "R1", "request after reset", 32'(memReqValid), 32'd0);

    for (int k = 0; k < NROWS; k++) runRow(ROWS[k]);

    // R11: register writes during a transfer are ignored
    prepare(32'h500, 16'd80, 1'b0, 1'b1, -1);
    regWrite(2'd0, 32'h500);
    regWrite(2'd1, 32'd80);
    regWrite(2'd2, 32'h1);
    repeat (3) @(negedge clk);
    regWrite(2'd0, 32'h900);
    regWrite(2'd1, 32'd4);
    regWrite(2'd2, 32'h0);
    regRead(2'd0, v);
    check(v == 32'h500, "R11", "base held while busy", v, 32'h500);
    regRead(2'd1, v);
    check(v == 32'd80, "R11", "count held while busy", v, 32'd80);
    regRead(2'd2, v);
    check(v[0] == 1'b1, "R11", "command held while busy", v, 32'h1);
    waitIdle();
    check(wordIdx == 20, "R11", "words after ignored writes", wordIdx, 32'd20);
    regRead(2'd3, v);
    check(v[2:0] == 3'b001, "R6", "done after long run", v, 32'h1);

    // R10: clearing only the error bit leaves done set
    regWrite(2'd3, 32'h2);
    regRead(2'd3, v);
    check(v[0] == 1'b1, "R10", "done kept on error-bit clear", v, 32'h1);
    regWrite(2'd3, 32'h1);
    regRead(2'd3, v);
    check(v[1:0] == 2'b00, "R10", "done cleared", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule